// File: doc/BRIEF.md
# Bus Width Adapter and Access Splitter

This unit joins a 32-bit internal master to an external memory bus that serves several chip-select spaces. Each space has a fixed device width of 8, 16 or 32 bits. Space 0 takes its width from strap inputs. The remaining spaces take their widths from a writable configuration register. The master asks for byte, word or longword transfers and holds its request until the unit finishes. The unit picks the width of the addressed space, divides the transfer into as many external cycles as that width requires, and places each slice on the big-endian lanes of the device. For reads it collects the returned slices into one right-justified result.

Requests that are misaligned, that use an unknown size code, or that name a space that does not exist are refused with an error pulse, and no external cycle is started. The external side uses a request/acknowledge handshake for each cycle, so a slow device can stretch any cycle as long as it needs.

Top module: `bus_width_adapter`

## Requirements
- R1: The width code of space 0 comes from `strap_cs0_w`. The code of space k (k ≥ 1) sits in `cfg_wdata[2k-1:2k-2]` and is loaded when `cfg_we` is high. Codes are 00 = 8-bit, 01 = 16-bit, 10 = 32-bit and 11 = 32-bit. After reset every configured space is 32-bit.
- R2: An access of S bytes (`m_size` 00 = byte, 01 = word, 10 = longword) to a device of D bytes takes S / min(S, D) external cycles.
- R3: The external cycles of one access run at ascending addresses in steps of min(S, D) bytes, starting at `m_addr`. The most significant part of the data goes first. `e_cs` and `e_we` follow the request.
- R4: On a 32-bit device, the byte at address offset n (n = addr mod 4) uses `e_wdata`/`e_rdata` bits [31-8n:24-8n]. A word uses the two lanes of its two bytes, and a longword uses all lanes.
- R5: On a 16-bit device, an even address uses lane [15:8] and an odd address uses [7:0]. On an 8-bit device every byte uses [7:0]. Write lanes that carry no data are driven to zero.
- R6: Read data is returned right-justified and zero-extended on `m_rdata`, assembled from the device lanes named in R4 and R5. Lanes the device drives outside the transfer are ignored.
- R7: A word at an odd address, a longword whose address is not a multiple of 4, size code 11, or a space index of `NUM_CS` or more raises `m_err` for exactly one cycle. No external cycle is started.
- R8: `e_req` stays high, with `e_addr` and `e_wdata` unchanged, until `e_ack` is sampled high. Each clock edge with both signals high completes one external cycle.
- R9: `m_done` rises for exactly one cycle, on the cycle after the final acknowledge, and never while `e_req` is high. The master drops `m_req` when it sees `m_done` or `m_err`.
- R10: The width is captured when an access is accepted. A configuration write during an access does not change that access's cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_cs0_w | input | 2 | Width code of space 0 |
| cfg_we | input | 1 | Load the width register |
| cfg_wdata | input | 2*(NUM_CS-1) | Width codes of spaces 1 and up |
| m_req | input | 1 | Master request, held until done or error |
| m_we | input | 1 | 1 = write |
| m_size | input | 2 | Access size code |
| m_cs | input | $clog2(NUM_CS) | Chip-select space index |
| m_addr | input | ADDR_W | Byte address |
| m_wdata | input | 32 | Right-justified write data |
| m_done | output | 1 | Access complete pulse |
| m_err | output | 1 | Access rejected pulse |
| m_rdata | output | 32 | Right-justified read data |
| e_req | output | 1 | External cycle request |
| e_we | output | 1 | External write |
| e_cs | output | $clog2(NUM_CS) | External space index |
| e_addr | output | ADDR_W | External byte address |
| e_wdata | output | 32 | External write lanes |
| e_rdata | input | 32 | External read lanes |
| e_ack | input | 1 | External cycle acknowledge |

## Verification
The hardest situation to reach is a configuration write that lands while an access is in flight, because the width must already be captured. The bench's device model watches for the first external cycle of a longword read to an 8-bit space. At that cycle it writes a 32-bit code for the same space, then checks that four cycles still follow. It also confirms that the next access uses the new width. Every cycle is stretched by a varying number of wait states, and the model fills the unused read lanes with a filler pattern. This shows that held cycles and lane masking behave correctly for every mix of width, size and offset.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } state_e;

  localparam logic [1:0] WCODE_32 = 2'b10;

  // Byte count of a master access size code.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Byte count of a device width code (11 behaves as 32-bit).
  function automatic logic [2:0] dev_bytes(input logic [1:0] wc);
    case (wc)
      2'd0:    dev_bytes = 3'd1;
      2'd1:    dev_bytes = 3'd2;
      default: dev_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bwa_width_table.sv
module bwa_width_table
  import bwa_pkg::*;
#(
  parameter int NUM_CS = 5,
  localparam int CSW   = $clog2(NUM_CS),
  localparam int CFG_W = 2 * (NUM_CS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_w,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [CSW-1:0]   sel_cs,
  output logic [1:0]       sel_w
);

  localparam logic [CSW-1:0] LAST_CS = CSW'(NUM_CS - 1);

  logic [1:0] w_arr [NUM_CS];

  assign w_arr[0] = strap_w;

  for (genvar k = 1; k < NUM_CS; k++) begin : g_space
    logic [1:0] wq;
    logic [1:0] wd;

    always_comb begin
      wd = wq;
      if (cfg_we) wd = cfg_wdata[2*k-1 -: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wq <= WCODE_32;
      else if (cfg_we) wq <= wd;
    end

    assign w_arr[k] = wq;
  end

  always_comb begin
    if (sel_cs > LAST_CS) sel_w = WCODE_32;
    else                  sel_w = w_arr[sel_cs];
  end

endmodule

// File: rtl/bwa_lane_steer.sv
module bwa_lane_steer
  import bwa_pkg::*;
(
  input  logic [1:0]  dev_w,
  input  logic [1:0]  addr_lo,
  input  logic [2:0]  step,
  input  logic [31:0] slice_wr,
  input  logic [31:0] bus_rd,
  output logic [31:0] bus_wr,
  output logic [31:0] slice_rd
);

  logic [2:0]  devb;
  logic [2:0]  offs;
  logic [2:0]  lane_sh;
  logic [5:0]  bit_sh;
  logic [31:0] mask;

  always_comb begin
    devb    = dev_bytes(dev_w);
    offs    = {1'b0, addr_lo & 2'(devb - 3'd1)};
    // lanes lying below the slice on this device
    lane_sh = devb - offs - step;
    bit_sh  = {lane_sh, 3'b000};
    case (step)
      3'd1:    mask = 32'h0000_00FF;
      3'd2:    mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
    bus_wr   = (slice_wr & mask) << bit_sh;
    slice_rd = (bus_rd >> bit_sh) & mask;
  end

endmodule

// File: rtl/bwa_seq.sv
module bwa_seq
  import bwa_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int ADDR_W = 26,
  localparam int CSW   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_req,
  input  logic              m_we,
  input  logic [1:0]        m_size,
  input  logic [CSW-1:0]    m_cs,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [31:0]       m_wdata,
  input  logic [1:0]        look_w,
  input  logic [31:0]       slice_rd,
  input  logic              e_ack,
  output logic              done_o,
  output logic              err_o,
  output logic              xfer_o,
  output logic              we_o,
  output logic [CSW-1:0]    cs_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        dw_o,
  output logic [2:0]        step_o,
  output logic [31:0]       slice_wr,
  output logic [31:0]       asm_o
);

  localparam logic [CSW-1:0] LAST_CS = CSW'(NUM_CS - 1);

  state_e            st_q, st_d;
  logic              we_q, we_d;
  logic [CSW-1:0]    cs_q, cs_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [31:0]       wdat_q, wdat_d;
  logic [1:0]        dw_q, dw_d;
  logic [2:0]        step_q, step_d;
  logic [2:0]        left_q, left_d;
  logic [31:0]       asm_q, asm_d;

  logic              bad;
  logic [2:0]        sz_b;
  logic [2:0]        dv_b;
  logic [2:0]        after;
  logic [5:0]        shamt;
  logic              ld_acc;
  logic              ld_beat;

  always_comb begin
    sz_b  = size_bytes(m_size);
    dv_b  = dev_bytes(look_w);
    bad   = (m_size == SZ_BAD) || (m_cs > LAST_CS) ||
            ((m_size == SZ_WORD) && m_addr[0]) ||
            ((m_size == SZ_LONG) && (m_addr[1:0] != 2'b00));
    after = left_q - step_q;
    shamt = {after, 3'b000};

    ld_acc  = (st_q == ST_IDLE) && m_req && !bad;
    ld_beat = (st_q == ST_XFER) && e_ack;

    st_d   = st_q;
    we_d   = we_q;
    cs_d   = cs_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    dw_d   = dw_q;
    step_d = step_q;
    left_d = left_q;
    asm_d  = asm_q;

    case (st_q)
      ST_IDLE: begin
        if (m_req) st_d = bad ? ST_ERR : ST_XFER;
        if (ld_acc) begin
          we_d   = m_we;
          cs_d   = m_cs;
          addr_d = m_addr;
          wdat_d = m_wdata;
          dw_d   = look_w;
          step_d = (sz_b < dv_b) ? sz_b : dv_b;
          left_d = sz_b;
          asm_d  = '0;
        end
      end
      ST_XFER: begin
        if (ld_beat) begin
          if (!we_q) asm_d = asm_q | (slice_rd << shamt);
          addr_d = addr_q + ADDR_W'(step_q);
          left_d = after;
          if (after == 3'd0) st_d = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      cs_q   <= '0;
      wdat_q <= '0;
      dw_q   <= WCODE_32;
      step_q <= 3'd4;
    end else if (ld_acc) begin
      we_q   <= we_d;
      cs_q   <= cs_d;
      wdat_q <= wdat_d;
      dw_q   <= dw_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= 3'd0;
      asm_q  <= '0;
    end else if (ld_acc || ld_beat) begin
      addr_q <= addr_d;
      left_q <= left_d;
      asm_q  <= asm_d;
    end
  end

  assign done_o   = (st_q == ST_DONE);
  assign err_o    = (st_q == ST_ERR);
  assign xfer_o   = (st_q == ST_XFER);
  assign we_o     = we_q;
  assign cs_o     = cs_q;
  assign addr_o   = addr_q;
  assign dw_o     = dw_q;
  assign step_o   = step_q;
  assign slice_wr = wdat_q >> shamt;
  assign asm_o    = asm_q;

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int ADDR_W = 26,
  localparam int CSW   = $clog2(NUM_CS),
  localparam int CFG_W = 2 * (NUM_CS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_cs0_w,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              m_req,
  input  logic              m_we,
  input  logic [1:0]        m_size,
  input  logic [CSW-1:0]    m_cs,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [31:0]       m_wdata,
  output logic              m_done,
  output logic              m_err,
  output logic [31:0]       m_rdata,
  output logic              e_req,
  output logic              e_we,
  output logic [CSW-1:0]    e_cs,
  output logic [ADDR_W-1:0] e_addr,
  output logic [31:0]       e_wdata,
  input  logic [31:0]       e_rdata,
  input  logic              e_ack
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [1:0]  look_w;
  logic [1:0]  dw;
  logic [2:0]  step;
  logic [31:0] slice_wr;
  logic [31:0] slice_rd;
  logic [31:0] lanes_wr;
  logic        xfer;

  bwa_width_table #(.NUM_CS(NUM_CS)) u_wtab (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .strap_w   (strap_cs0_w),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .sel_cs    (m_cs),
    .sel_w     (look_w)
  );

  bwa_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .m_req    (m_req),
    .m_we     (m_we),
    .m_size   (m_size),
    .m_cs     (m_cs),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .look_w   (look_w),
    .slice_rd (slice_rd),
    .e_ack    (e_ack),
    .done_o   (m_done),
    .err_o    (m_err),
    .xfer_o   (xfer),
    .we_o     (e_we),
    .cs_o     (e_cs),
    .addr_o   (e_addr),
    .dw_o     (dw),
    .step_o   (step),
    .slice_wr (slice_wr),
    .asm_o    (m_rdata)
  );

  bwa_lane_steer u_steer (
    .dev_w    (dw),
    .addr_lo  (e_addr[1:0]),
    .step     (step),
    .slice_wr (slice_wr),
    .bus_rd   (e_rdata),
    .bus_wr   (lanes_wr),
    .slice_rd (slice_rd)
  );

  assign e_req   = xfer;
  assign e_wdata = (xfer && e_we) ? lanes_wr : 32'h0;

endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_done,
  input logic              m_err,
  input logic              e_req,
  input logic              e_ack,
  input logic [ADDR_W-1:0] e_addr,
  input logic [31:0]       e_wdata
);

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (e_req && !e_ack) |=> (e_req && $stable(e_addr) && $stable(e_wdata)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |=> !m_done);

  assert_done_not_in_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |-> !e_req);

  assert_err_no_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> (!e_req && !m_done));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |=> (!m_err && !e_req));

endmodule

bind bus_width_adapter bwa_checker #(.ADDR_W(ADDR_W)) u_bwa_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_done  (m_done),
  .m_err   (m_err),
  .e_req   (e_req),
  .e_ack   (e_ack),
  .e_addr  (e_addr),
  .e_wdata (e_wdata)
);

// File: tb/bus_width_adapter_bench.sv
module bus_width_adapter_bench;

  localparam int NCS = 5;
  localparam int AW  = 8;

  logic        clk;
  logic        rst_n;
  logic [1:0]  strap_cs0_w;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic        m_req, m_we;
  logic [1:0]  m_size;
  logic [2:0]  m_cs;
  logic [7:0]  m_addr;
  logic [31:0] m_wdata;
  logic        m_done, m_err;
  logic [31:0] m_rdata;
  logic        e_req, e_we;
  logic [2:0]  e_cs;
  logic [7:0]  e_addr;
  logic [31:0] e_wdata;
  logic [31:0] e_rdata;
  logic        e_ack;

  bus_width_adapter #(.NUM_CS(NCS), .ADDR_W(AW)) u_bus_width_adapter (
    .clk(clk), .rst_n(rst_n), .strap_cs0_w(strap_cs0_w),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .m_req(m_req), .m_we(m_we), .m_size(m_size), .m_cs(m_cs),
    .m_addr(m_addr), .m_wdata(m_wdata),
    .m_done(m_done), .m_err(m_err), .m_rdata(m_rdata),
    .e_req(e_req), .e_we(e_we), .e_cs(e_cs), .e_addr(e_addr),
    .e_wdata(e_wdata), .e_rdata(e_rdata), .e_ack(e_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  int seq_no  = 0;
  logic [7:0] mem [0:NCS*256-1];
  int wbytes [0:NCS-1];   // bench model of device widths in bytes

  function automatic int code2b(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] w1, input logic [1:0] w2,
                           input logic [1:0] w3, input logic [1:0] w4);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {w4, w3, w2, w1};
    @(negedge clk);
    cfg_we = 1'b0;
    wbytes[1] = code2b(w1); wbytes[2] = code2b(w2);
    wbytes[3] = code2b(w3); wbytes[4] = code2b(w4);
  endtask

  // One master access with a device model; mid_cfg rewrites space 1 to 32-bit
  // during the first external cycle.
  task automatic access(input bit we, input logic [1:0] size, input logic [2:0] cs,
                        input logic [7:0] addr, input logic [31:0] wd, input bit mid_cfg);
    int sb, db, step, ncyc_exp, ncyc, waitc, tmo;
    bit bad, newcyc, got_done, got_err;
    logic [31:0] exp_rd, exp_w, rd;
    sb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    bad = (size == 2'd3) || (cs > 3'd4) || (size == 2'd1 && addr[0]) ||
          (size == 2'd2 && addr[1:0] != 2'b00);
    db = (cs > 3'd4) ? 4 : wbytes[cs];
    step = (sb < db) ? sb : db;
    ncyc_exp = sb / step;
    exp_rd = 32'h0;
    if (!bad)
      for (int k = 0; k < sb; k++)
        exp_rd = (exp_rd << 8) | 32'(mem[int'(cs)*256 + ((int'(addr) + k) % 256)]);
    seq_no++;
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_size = size; m_cs = cs; m_addr = addr; m_wdata = wd;
    ncyc = 0; waitc = 0; newcyc = 1'b1; got_done = 1'b0; got_err = 1'b0; tmo = 0;
    while (!got_done && !got_err && tmo < 100) begin
      @(negedge clk);
      tmo++;
      cfg_we = 1'b0;
      if (e_ack) begin e_ack = 1'b0; newcyc = 1'b1; end
      if (m_done) got_done = 1'b1;
      else if (m_err) got_err = 1'b1;
      else if (e_req) begin
        if (newcyc) begin
          chk(e_addr == 8'(int'(addr) + ncyc * step), "R3 cycle address",
              32'(e_addr), 32'(8'(int'(addr) + ncyc * step)));
          chk(e_cs == cs && e_we == we, "R3 space/direction",
              {28'h0, e_cs, e_we}, {28'h0, cs, we});
          if (we) begin
            exp_w = 32'h0;
            for (int j = 0; j < step; j++) begin
              int x, lane, kk;
              logic [31:0] b;
              kk = ncyc * step + j;
              b = (wd >> ((sb - 1 - kk) * 8)) & 32'hFF;
              x = (int'(e_addr) + j) % 256;
              lane = db - 1 - (x % db);
              exp_w = exp_w | (b << (lane * 8));
              mem[int'(cs)*256 + x] = e_wdata[lane*8 +: 8];
            end
            chk(e_wdata == exp_w, (db == 4) ? "R4 write lanes" : "R5 write lanes",
                e_wdata, exp_w);
          end
          if (mid_cfg && ncyc == 0) begin
            cfg_we = 1'b1;
            cfg_wdata = {2'b10, 2'b10, 2'b10, 2'b10};
          end
          ncyc++;
          waitc = (ncyc + seq_no) % 3;
          newcyc = 1'b0;
        end
        if (waitc == 0) begin
          rd = 32'hA5A5_A5A5;
          for (int j = 0; j < step; j++) begin
            int x, lane;
            x = (int'(e_addr) + j) % 256;
            lane = db - 1 - (x % db);
            rd[lane*8 +: 8] = mem[int'(cs)*256 + x];
          end
          e_rdata = rd;
          e_ack = 1'b1;
        end else waitc--;
      end
    end
    m_req = 1'b0;
    e_ack = 1'b0;
    if (bad) begin
      chk(got_err && ncyc == 0, "R7 rejected without cycle",
          {got_err, 31'(ncyc)}, {1'b1, 31'd0});
    end else begin
      chk(got_done, "R9 completion", {31'h0, got_done}, 32'd1);
      chk(ncyc == ncyc_exp, (mid_cfg) ? "R10 width captured" : "R2 cycle count",
          32'(ncyc), 32'(ncyc_exp));
      if (!we) chk(m_rdata == exp_rd, "R6 read assembly", m_rdata, exp_rd);
    end
    @(negedge clk);
    chk(!m_done && !m_err, "R9 single pulse", {30'h0, m_done, m_err}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap_cs0_w = 2'b10; cfg_we = 1'b0; cfg_wdata = '0;
    m_req = 1'b0; m_we = 1'b0; m_size = 2'b00; m_cs = '0; m_addr = '0;
    m_wdata = '0; e_rdata = '0; e_ack = 1'b0;
    for (int i = 0; i < NCS*256; i++) mem[i] = 8'(i * 37 + 11);
    for (int i = 0; i < NCS; i++) wbytes[i] = 4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state; configured spaces start 32-bit (R1)
    chk(!m_done && !m_err && !e_req, "R9 reset outputs idle",
        {29'h0, m_done, m_err, e_req}, 32'h0);
    for (int c = 1; c < NCS; c++) access(1'b0, 2'd2, 3'(c), 8'h20, 32'h0, 1'b0);

    for (int s = 0; s < 3; s++) begin
      strap_cs0_w = 2'(s);
      wbytes[0] = code2b(2'(s));
      cfg_write(2'(s), 2'((s + 1) % 3), 2'((s + 2) % 3), 2'b11);   // R1 field layout
      for (int c = 0; c < 8; c++)
        for (int sz = 0; sz < 4; sz++)
          for (int off = 0; off < 4; off++)
            for (int w = 1; w >= 0; w--) begin
              if (c > 4 && (sz > 0 || off > 0)) continue;
              access(1'(w), 2'(sz), 3'(c), 8'(8'h40 + 8'(s * 16) + 8'(off)),
                     32'h9E37_79B9 * 32'(c * 64 + sz * 16 + off * 4 + s + 1), 1'b0);
            end
    end

    // R10: reconfigure space 1 while an 8-bit longword read is running
    cfg_write(2'b00, 2'b01, 2'b10, 2'b00);
    access(1'b0, 2'd2, 3'd1, 8'h80, 32'h0, 1'b1);
    wbytes[1] = 4; wbytes[2] = 4; wbytes[3] = 4; wbytes[4] = 4;
    access(1'b0, 2'd2, 3'd1, 8'h80, 32'h0, 1'b0);
    access(1'b1, 2'd2, 3'd4, 8'h84, 32'hCAFE_F00D, 1'b0);
    access(1'b0, 2'd2, 3'd4, 8'h84, 32'h0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule